// File: doc/BRIEF.md
# Outstanding Line Request Tracker

This block records every memory request that one core has in flight toward its first-level cache controller. A request is identified by its cache-line address: the request address with the low offset bits cleared. Read-class requests go into one table and write-class requests into another. Each new request gets a status in the same cycle it is offered. It is accepted, refused as aliased because the line is already in flight or locked, or refused because the outstanding limit is reached. A completion names a line and a table, and it frees the matching entry.

Each entry ages while it waits. A watchdog state machine has two states, `WD_IDLE` and `WD_ARMED`. The transition *arm* (`WD_IDLE` to `WD_ARMED`) is taken on an accepted request. In `WD_ARMED` a timer counts up to the threshold. At that point the transition *check* inspects every entry's age. It then either *re-arm*s (stays in `WD_ARMED` with the timer cleared) when requests remain, or *retire*s (goes to `WD_IDLE`) when none remain. A check that finds an entry at or above the threshold raises a sticky deadlock flag. Four saturating counters record the aliasing refusals, one counter for each pairing of request class and blocking table.

Top module: `line_req_tracker`

## Requirements
- R1: After reset, `out_count`, `deadlock` and all four refusal counters are 0, and `iss_status` is 0 while `iss_valid` is low.
- R2: `iss_status` encodes 0 = no request, 1 = accepted, 2 = aliased, 3 = full. `iss_kind` encodes 0 load, 1 instruction fetch, 2 store, 3 RMW read, 4 RMW write, 5 load-linked, 6 store-conditional, 7 locked RMW read, 8 locked RMW write, 9 flush. Codes 2 to 9 are write-class and all other codes are read-class.
- R3: When `out_count` equals `MAX_OUT`, a request is refused as full. This check takes priority over every aliasing check.
- R4: When `iss_lock_hit` is high, any kind other than 8 is refused as aliased. Kind 8 proceeds to the table checks.
- R5: A write-class request whose line is in the read table is aliased and increments `cnt_st_ld`. Otherwise, one whose line is in the write table is aliased and increments `cnt_st_st`.
- R6: A read-class request whose line is in the write table is aliased and increments `cnt_ld_st`. Otherwise, one whose line is in the read table is aliased and increments `cnt_ld_ld`.
- R7: The line address is the address without its low `OFFS_W` bits. Addresses in the same line collide, and addresses in adjacent lines do not.
- R8: `out_count` rises by one per accepted request and falls by one per completion. A completion (`cmp_is_write` picks the table) frees its line, after which the line is accepted again. An issue and a completion in the same cycle both take effect.
- R9: Each refusal counter saturates at 2^`CNT_W`-1. Full and lock refusals change no counter.
- R10: The deadlock flag rises only at a watchdog check, which comes `WD_THRESH` cycles after arming. It rises if an entry's age is at or above `WD_THRESH`, and it stays high until reset.
- R11: After a check the watchdog re-arms for another period only if requests are still outstanding. An entry that is young at one check is therefore caught by the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | A request is offered this cycle |
| iss_addr | input | ADDR_W | Request address |
| iss_kind | input | 4 | Request kind code |
| iss_lock_hit | input | 1 | The offered request's line is held by a locked RMW |
| iss_status | output | 2 | Same-cycle verdict on the offered request |
| cmp_valid | input | 1 | A completion arrives this cycle |
| cmp_addr | input | ADDR_W | Completion line address |
| cmp_is_write | input | 1 | Completion targets the write table |
| out_count | output | clog2(MAX_OUT+1) | Requests outstanding |
| deadlock | output | 1 | Sticky watchdog flag |
| cnt_st_ld | output | CNT_W | Write-class refused behind a read |
| cnt_st_st | output | CNT_W | Write-class refused behind a write |
| cnt_ld_st | output | CNT_W | Read-class refused behind a write |
| cnt_ld_ld | output | CNT_W | Read-class refused behind a read |

## Verification
Wrong table contents show at `iss_status` on the very next request to that line: a stale entry gives a false alias, and a lost entry gives a false accept. The wrong refusal counter also moves in that same cycle. A count that drifts from the table contents shows as an early or missing full refusal, and the checker flags it in the cycle it happens. Watchdog timing faults appear only at check boundaries, so the bench places a young entry across one check and an old one across the next.

// File: rtl/lrt_pkg.sv
package lrt_pkg;

    typedef enum logic [3:0] {
        K_LOAD    = 4'd0,
        K_IFETCH  = 4'd1,
        K_STORE   = 4'd2,
        K_RMW_RD  = 4'd3,
        K_RMW_WR  = 4'd4,
        K_LINK_LD = 4'd5,
        K_COND_ST = 4'd6,
        K_LOCK_RD = 4'd7,
        K_LOCK_WR = 4'd8,
        K_FLUSH   = 4'd9
    } req_kind_e;

    typedef enum logic [1:0] {
        ST_NONE   = 2'd0,
        ST_ACCEPT = 2'd1,
        ST_ALIAS  = 2'd2,
        ST_FULL   = 2'd3
    } iss_status_e;

    typedef enum logic {
        WD_IDLE  = 1'b0,
        WD_ARMED = 1'b1
    } wd_state_e;

    // refusal counter slots
    localparam int NUM_REFUSE = 4;
    localparam int RF_ST_LD   = 0;
    localparam int RF_ST_ST   = 1;
    localparam int RF_LD_ST   = 2;
    localparam int RF_LD_LD   = 3;

    function automatic logic is_write_class(logic [3:0] kind);
        return (kind >= 4'(K_STORE)) && (kind <= 4'(K_FLUSH));
    endfunction

endpackage

// File: rtl/lrt_table.sv
module lrt_table #(
    parameter int DEPTH   = 4,
    parameter int LINE_W  = 12,
    parameter int AGE_MAX = 16,
    localparam int OCC_W  = $clog2(DEPTH + 1),
    localparam int AGE_W  = $clog2(AGE_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] look_line,
    output logic              look_hit,
    input  logic              alloc_en,
    input  logic              free_en,
    input  logic [LINE_W-1:0] free_line,
    output logic              free_hit,
    output logic              aged,
    output logic [OCC_W-1:0]  occ
);

    logic [DEPTH-1:0]  vld;
    logic [LINE_W-1:0] tag [DEPTH];
    logic [AGE_W-1:0]  age [DEPTH];
    logic [DEPTH-1:0]  look_m;
    logic [DEPTH-1:0]  free_m;
    logic [DEPTH-1:0]  old_m;
    logic [DEPTH-1:0]  alloc_m;

    // first free slot, one-hot
    always_comb begin
        alloc_m = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!vld[i] && (alloc_m == '0)) alloc_m[i] = 1'b1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign look_m[g] = vld[g] && (tag[g] == look_line);
        assign free_m[g] = vld[g] && (tag[g] == free_line);
        assign old_m[g]  = vld[g] && (age[g] >= AGE_W'(AGE_MAX));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld[g] <= 1'b0;
                tag[g] <= '0;
                age[g] <= '0;
            end else if (alloc_en && alloc_m[g]) begin
                vld[g] <= 1'b1;
                tag[g] <= look_line;
                age[g] <= '0;
            end else if (free_en && free_m[g]) begin
                vld[g] <= 1'b0;
            end else if (vld[g] && (age[g] != AGE_W'(AGE_MAX))) begin
                age[g] <= age[g] + AGE_W'(1);
            end
        end
    end

    assign look_hit = |look_m;
    assign free_hit = |free_m;
    assign aged     = |old_m;
    assign occ      = OCC_W'($countones(vld));

endmodule

// File: rtl/lrt_sat_cnt.sv
module lrt_sat_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] val
);

    always_ff @(posedge clk) begin
        if (!rst_n)                 val <= '0;
        else if (inc && (val != '1)) val <= val + W'(1);
    end

endmodule

// File: rtl/lrt_watchdog.sv
module lrt_watchdog
    import lrt_pkg::*;
#(
    parameter int THRESH = 16,
    localparam int TMR_W = $clog2(THRESH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic pending,
    input  logic aged,
    output logic deadlock
);

    wd_state_e        state, state_n;
    logic [TMR_W-1:0] tmr, tmr_n;
    logic             fire;

    always_comb begin
        state_n = state;
        tmr_n   = tmr;
        fire    = 1'b0;
        unique case (state)
            WD_IDLE: begin
                if (arm) begin
                    state_n = WD_ARMED;   // arm
                    tmr_n   = '0;
                end
            end
            WD_ARMED: begin
                if (tmr == TMR_W'(THRESH)) begin
                    fire  = 1'b1;         // check
                    tmr_n = '0;
                    state_n = pending ? WD_ARMED : WD_IDLE;  // re-arm / retire
                end else begin
                    tmr_n = tmr + TMR_W'(1);
                end
            end
            default: state_n = WD_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WD_IDLE;
            tmr   <= '0;
        end else begin
            state <= state_n;
            tmr   <= tmr_n;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n)             deadlock <= 1'b0;
        else if (fire && aged)  deadlock <= 1'b1;
    end

endmodule

// File: rtl/line_req_tracker.sv
module line_req_tracker
    import lrt_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int OFFS_W    = 4,
    parameter int TBL_DEPTH = 4,
    parameter int MAX_OUT   = 4,
    parameter int WD_THRESH = 16,
    parameter int CNT_W     = 4,
    localparam int LINE_W    = ADDR_W - OFFS_W,
    localparam int CNT_OUT_W = $clog2(MAX_OUT + 1),
    localparam int OCC_W     = $clog2(TBL_DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 iss_valid,
    input  logic [ADDR_W-1:0]    iss_addr,
    input  logic [3:0]           iss_kind,
    input  logic                 iss_lock_hit,
    output logic [1:0]           iss_status,
    input  logic                 cmp_valid,
    input  logic [ADDR_W-1:0]    cmp_addr,
    input  logic                 cmp_is_write,
    output logic [CNT_OUT_W-1:0] out_count,
    output logic                 deadlock,
    output logic [CNT_W-1:0]     cnt_st_ld,
    output logic [CNT_W-1:0]     cnt_st_st,
    output logic [CNT_W-1:0]     cnt_ld_st,
    output logic [CNT_W-1:0]     cnt_ld_ld
);

    logic [LINE_W-1:0]    iss_line, cmp_line;
    logic                 unused_offs;
    logic                 is_wr, accept;
    logic                 rd_hit, wr_hit;
    logic                 rd_free_hit, wr_free_hit;
    logic                 rd_aged, wr_aged;
    logic [OCC_W-1:0]     rd_occ, wr_occ;
    logic [CNT_OUT_W-1:0] count_n;
    logic [NUM_REFUSE-1:0] bump;
    logic [CNT_W-1:0]     cnt_v [NUM_REFUSE];
    iss_status_e          status;

    assign iss_line    = iss_addr[ADDR_W-1:OFFS_W];
    assign cmp_line    = cmp_addr[ADDR_W-1:OFFS_W];
    assign unused_offs = ^{iss_addr[OFFS_W-1:0], cmp_addr[OFFS_W-1:0]};
    assign is_wr       = is_write_class(iss_kind);

    // verdict: full, then lock, then cross table, then own table
    always_comb begin
        status = ST_NONE;
        bump   = '0;
        if (iss_valid) begin
            if (out_count == CNT_OUT_W'(MAX_OUT)) begin
                status = ST_FULL;
            end else if (iss_lock_hit && (iss_kind != 4'(K_LOCK_WR))) begin
                status = ST_ALIAS;
            end else if (is_wr) begin
                if (rd_hit) begin
                    status = ST_ALIAS;
                    bump[RF_ST_LD] = 1'b1;
                end else if (wr_hit) begin
                    status = ST_ALIAS;
                    bump[RF_ST_ST] = 1'b1;
                end else begin
                    status = ST_ACCEPT;
                end
            end else begin
                if (wr_hit) begin
                    status = ST_ALIAS;
                    bump[RF_LD_ST] = 1'b1;
                end else if (rd_hit) begin
                    status = ST_ALIAS;
                    bump[RF_LD_LD] = 1'b1;
                end else begin
                    status = ST_ACCEPT;
                end
            end
        end
    end

    assign iss_status = status;
    assign accept     = (status == ST_ACCEPT);

    lrt_table #(.DEPTH(TBL_DEPTH), .LINE_W(LINE_W), .AGE_MAX(WD_THRESH)) u_rd_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_line (iss_line),
        .look_hit  (rd_hit),
        .alloc_en  (accept && !is_wr),
        .free_en   (cmp_valid && !cmp_is_write),
        .free_line (cmp_line),
        .free_hit  (rd_free_hit),
        .aged      (rd_aged),
        .occ       (rd_occ)
    );

    lrt_table #(.DEPTH(TBL_DEPTH), .LINE_W(LINE_W), .AGE_MAX(WD_THRESH)) u_wr_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_line (iss_line),
        .look_hit  (wr_hit),
        .alloc_en  (accept && is_wr),
        .free_en   (cmp_valid && cmp_is_write),
        .free_line (cmp_line),
        .free_hit  (wr_free_hit),
        .aged      (wr_aged),
        .occ       (wr_occ)
    );

    always_comb begin
        count_n = out_count;
        if (accept)    count_n = count_n + CNT_OUT_W'(1);
        if (cmp_valid) count_n = count_n - CNT_OUT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_count <= '0;
        else        out_count <= count_n;
    end

    lrt_watchdog #(.THRESH(WD_THRESH)) u_wd (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (accept),
        .pending  (count_n != '0),
        .aged     (rd_aged || wr_aged),
        .deadlock (deadlock)
    );

    for (genvar g = 0; g < NUM_REFUSE; g++) begin : g_refuse
        lrt_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (bump[g]),
            .val   (cnt_v[g])
        );
    end

    assign cnt_st_ld = cnt_v[RF_ST_LD];
    assign cnt_st_st = cnt_v[RF_ST_ST];
    assign cnt_ld_st = cnt_v[RF_LD_ST];
    assign cnt_ld_ld = cnt_v[RF_LD_LD];

endmodule

// File: rtl/lrt_checker.sv
module lrt_checker
    import lrt_pkg::*;
#(
    parameter int MAX_OUT   = 4,
    parameter int CNT_OUT_W = 3,
    parameter int OCC_W     = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 iss_valid,
    input logic [3:0]           iss_kind,
    input logic                 iss_lock_hit,
    input logic [1:0]           iss_status,
    input logic                 cmp_valid,
    input logic                 cmp_is_write,
    input logic                 rd_free_hit,
    input logic                 wr_free_hit,
    input logic [CNT_OUT_W-1:0] out_count,
    input logic [OCC_W-1:0]     rd_occ,
    input logic [OCC_W-1:0]     wr_occ,
    input logic                 deadlock
);

    AST_IDLE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_valid |-> iss_status == 2'(ST_NONE)); // R2

    AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        int'(out_count) <= MAX_OUT); // R3

    AST_FULL_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_status == 2'(ST_FULL)) && !cmp_valid |=> out_count == $past(out_count)); // R3

    AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && iss_lock_hit && (iss_kind != 4'(K_LOCK_WR)) |-> iss_status != 2'(ST_ACCEPT)); // R4

    AST_COUNT_TRACKS_TABLES: assert property (@(posedge clk) disable iff (!rst_n)
        int'(out_count) == int'(rd_occ) + int'(wr_occ)); // R8

    AST_ACCEPT_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_status == 2'(ST_ACCEPT)) && !cmp_valid |=> int'(out_count) == int'($past(out_count)) + 1); // R8

    AST_CMP_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |-> (cmp_is_write ? wr_free_hit : rd_free_hit)); // R8

    AST_DEADLOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        deadlock |=> deadlock); // R10

endmodule

bind line_req_tracker lrt_checker #(
    .MAX_OUT   (MAX_OUT),
    .CNT_OUT_W (CNT_OUT_W),
    .OCC_W     (OCC_W)
) u_lrt_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .iss_valid    (iss_valid),
    .iss_kind     (iss_kind),
    .iss_lock_hit (iss_lock_hit),
    .iss_status   (iss_status),
    .cmp_valid    (cmp_valid),
    .cmp_is_write (cmp_is_write),
    .rd_free_hit  (rd_free_hit),
    .wr_free_hit  (wr_free_hit),
    .out_count    (out_count),
    .rd_occ       (rd_occ),
    .wr_occ       (wr_occ),
    .deadlock     (deadlock)
);

// File: tb/line_req_tracker_bench.sv
module line_req_tracker_bench;
    import lrt_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam int OFFS_W     = 4;
    localparam int DEPTH      = 4;
    localparam int MAX_OUT    = 4;
    localparam int THRESH     = 64;
    localparam int CNT_W      = 4;
    localparam int CNT_OUT_W  = $clog2(MAX_OUT + 1);
    localparam int CNT_SAT    = (1 << CNT_W) - 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 iss_valid = 1'b0;
    logic [ADDR_W-1:0]    iss_addr = '0;
    logic [3:0]           iss_kind = '0;
    logic                 iss_lock_hit = 1'b0;
    logic [1:0]           iss_status;
    logic                 cmp_valid = 1'b0;
    logic [ADDR_W-1:0]    cmp_addr = '0;
    logic                 cmp_is_write = 1'b0;
    logic [CNT_OUT_W-1:0] out_count;
    logic                 deadlock;
    logic [CNT_W-1:0]     cnt_st_ld, cnt_st_st, cnt_ld_st, cnt_ld_ld;

    line_req_tracker #(
        .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .TBL_DEPTH(DEPTH),
        .MAX_OUT(MAX_OUT), .WD_THRESH(THRESH), .CNT_W(CNT_W)
    ) u_line_req_tracker (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_addr(iss_addr), .iss_kind(iss_kind),
        .iss_lock_hit(iss_lock_hit), .iss_status(iss_status),
        .cmp_valid(cmp_valid), .cmp_addr(cmp_addr), .cmp_is_write(cmp_is_write),
        .out_count(out_count), .deadlock(deadlock),
        .cnt_st_ld(cnt_st_ld), .cnt_st_st(cnt_st_st),
        .cnt_ld_st(cnt_ld_st), .cnt_ld_ld(cnt_ld_ld)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    typedef struct {
        logic [1:0] st;
        string      req;
    } exp_t;
    exp_t sb[$];
    exp_t cur;

    task automatic check(int act, int exp, string req, string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // monitor: compare each offered request's verdict with the scoreboard
    always @(negedge clk) begin
        if (rst_n && iss_valid) begin
            if (sb.size() == 0) begin
                check(int'(iss_status), -1, "R2", "unscheduled verdict");
            end else begin
                cur = sb.pop_front();
                check(int'(iss_status), int'(cur.st), cur.req, "issue verdict");
            end
        end
    end

    // driver tasks: each holds its stimulus across exactly one rising edge
    task automatic issue(input logic [ADDR_W-1:0] a, input req_kind_e k, input logic lk,
                         input iss_status_e exp, input string req);
        @(posedge clk); #1;
        iss_valid = 1'b1; iss_addr = a; iss_kind = 4'(k); iss_lock_hit = lk;
        cmp_valid = 1'b0;
        sb.push_back('{st: 2'(exp), req: req});
    endtask

    task automatic complete(input logic [ADDR_W-1:0] a, input logic w);
        @(posedge clk); #1;
        iss_valid = 1'b0; iss_lock_hit = 1'b0;
        cmp_valid = 1'b1; cmp_addr = a; cmp_is_write = w;
    endtask

    task automatic both(input logic [ADDR_W-1:0] a, input req_kind_e k,
                        input iss_status_e exp, input string req,
                        input logic [ADDR_W-1:0] ca, input logic cw);
        @(posedge clk); #1;
        iss_valid = 1'b1; iss_addr = a; iss_kind = 4'(k); iss_lock_hit = 1'b0;
        cmp_valid = 1'b1; cmp_addr = ca; cmp_is_write = cw;
        sb.push_back('{st: 2'(exp), req: req});
    endtask

    task automatic idle();
        @(posedge clk); #1;
        iss_valid = 1'b0; iss_lock_hit = 1'b0; cmp_valid = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        wait_n(3);
        // R1 reset state
        check(int'(out_count), 0, "R1", "count in reset");
        check(int'(deadlock), 0, "R1", "deadlock in reset");
        check(int'(iss_status), 0, "R1", "status idle");
        check(int'(cnt_st_ld) + int'(cnt_st_st) + int'(cnt_ld_st) + int'(cnt_ld_ld), 0,
              "R1", "refusal counters");
        rst_n = 1'b1;
        wait_n(1);

        // class decode and aliasing
        issue(16'h0100, K_LOAD,   1'b0, ST_ACCEPT, "R2 load accepted");
        issue(16'h0108, K_LOAD,   1'b0, ST_ALIAS,  "R6 R7 load behind load same line");
        issue(16'h0104, K_STORE,  1'b0, ST_ALIAS,  "R5 store behind load");
        issue(16'h0200, K_STORE,  1'b0, ST_ACCEPT, "R2 store accepted");
        issue(16'h0200, K_IFETCH, 1'b0, ST_ALIAS,  "R6 fetch behind store");
        issue(16'h020F, K_FLUSH,  1'b0, ST_ALIAS,  "R5 flush behind store");
        idle();
        check(int'(out_count), 2, "R8", "count after two accepts");
        check(int'(cnt_ld_ld), 1, "R6", "cnt_ld_ld");
        check(int'(cnt_st_ld), 1, "R5", "cnt_st_ld");
        check(int'(cnt_ld_st), 1, "R6", "cnt_ld_st");
        check(int'(cnt_st_st), 1, "R5", "cnt_st_st");

        issue(16'h0110, K_LOAD,    1'b0, ST_ACCEPT, "R7 adjacent line accepted");
        issue(16'h0300, K_LOCK_WR, 1'b1, ST_ACCEPT, "R4 locked write passes lock");
        issue(16'h0400, K_LOAD,    1'b0, ST_FULL,   "R3 full");
        issue(16'h0100, K_STORE,   1'b0, ST_FULL,   "R3 full before alias");
        idle();
        check(int'(out_count), 4, "R3", "count at limit");
        check(int'(cnt_st_ld), 1, "R9", "full refusal not counted");

        complete(16'h0110, 1'b0);
        both(16'h0600, K_LOAD, ST_ACCEPT, "R8 issue with completion", 16'h0200, 1'b1);
        idle();
        check(int'(out_count), 3, "R8", "count after same-cycle issue and completion");
        complete(16'h0100, 1'b0);
        complete(16'h0300, 1'b1);
        complete(16'h0600, 1'b0);
        idle();
        check(int'(out_count), 0, "R8", "count after retiring all");

        issue(16'h0700, K_LOAD,    1'b1, ST_ALIAS, "R4 load on locked line");
        issue(16'h0700, K_LOCK_RD, 1'b1, ST_ALIAS, "R4 locked read on locked line");
        idle();
        check(int'(cnt_ld_ld), 1, "R9", "lock refusal not counted");
        check(int'(out_count), 0, "R4", "nothing entered");

        issue(16'h0200, K_STORE, 1'b0, ST_ACCEPT, "R8 freed line accepted again");
        for (int i = 0; i < 18; i++) begin
            issue(16'h0208, K_STORE, 1'b0, ST_ALIAS, "R9 repeated store alias");
        end
        idle();
        check(int'(cnt_st_st), CNT_SAT, "R9", "cnt_st_st saturates");
        check(int'(cnt_st_ld), 1, "R9", "other counter untouched");
        complete(16'h0200, 1'b1);
        idle();
        check(int'(out_count), 0, "R8", "count zero again");

        // let the watchdog go idle; no entry ever aged out
        wait_n(2 * THRESH + 4);
        check(int'(deadlock), 0, "R10", "no deadlock when retired in time");

        // young entry at first check, old at second
        issue(16'h0800, K_LOAD, 1'b0, ST_ACCEPT, "R10 arming request");
        idle();
        wait_n(3);
        complete(16'h0800, 1'b0);
        idle();
        wait_n(4);
        issue(16'h0900, K_RMW_RD, 1'b0, ST_ACCEPT, "R11 late request");
        idle();
        wait_n(THRESH + 3);
        check(int'(deadlock), 0, "R10", "old entry waits for next check");
        wait_n(THRESH);
        check(int'(deadlock), 1, "R11", "re-armed check flags old entry");
        complete(16'h0900, 1'b1);
        idle();
        wait_n(2);
        check(int'(deadlock), 1, "R10", "deadlock sticky after retire");

        rst_n = 1'b0;
        wait_n(2);
        check(int'(deadlock), 0, "R1", "reset clears deadlock");
        check(int'(cnt_st_st), 0, "R1", "reset clears counters");
        rst_n = 1'b1;
        wait_n(2);
        check(sb.size(), 0, "R2", "scoreboard drained");
        finish_run();
    end

endmodule